// File: doc/BRIEF.md
# Integer Execution Unit with Byte Swap

This block runs register-to-register and register-immediate integer instructions from a 64-bit instruction word in the common in-kernel virtual machine format. It holds its own eleven-entry, 64-bit register file. The top entry is a frame register. It reads as a constant base value and cannot be written. The host offers one instruction at a time on a valid/ready port. The unit reads the destination operand and the second operand, computes in 32-bit or 64-bit width as the class field selects, writes the result back, and pulses `done`. It raises `illegal` in the same cycle if it rejected the instruction.

Byte-order conversion is part of the operation set. It works on the destination register alone. The immediate gives the conversion width and the source bit gives the target byte order, for a little-endian host. A debug port reads any register combinationally, and this is how the host observes results.

Top module: `ixu_top`

## Requirements
- R1: The instruction word is split, from bit 0 upward, into opcode [7:0], destination index [11:8], source index [15:12], offset [31:16] and immediate [63:32]. Opcode bits [2:0] are the class: 4 selects 32-bit width and 7 selects 64-bit width. Bits [7:4] are the operation. The offset must be zero.
- R2: An instruction is taken on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` is low in the following cycle. `done` is high for exactly one cycle, starting at the second edge after acceptance, and `op_ready` is high again in that same cycle.
- R3: Opcode bit 3 chooses the second operand. When it is 0, the operand is the immediate sign-extended to 64 bits. When it is 1, the operand is the register named by the source index.
- R4: Operations 0x0 add, 0x1 subtract, 0x2 multiply (low half), 0x4 or, 0x5 and, 0xa xor and 0xb move act on the destination and the operand. Operation 0x8 replaces the destination with its two's-complement negation.
- R5: In 32-bit width both inputs are cut to their low 32 bits before the operation, and the 32-bit result is zero-extended into the destination.
- R6: Operation 0x6 is a left shift, 0x7 a logical right shift and 0xc an arithmetic right shift. The shift amount is the operand's low 5 bits in 32-bit width and its low 6 bits in 64-bit width.
- R7: Operation 0x3 is an unsigned quotient and 0x9 an unsigned remainder. A zero divisor gives a quotient of 0. A zero divisor in a remainder leaves the destination as it was, with no illegal flag.
- R8: Operation 0xd, legal only in class 4, converts byte order. The immediate selects a width of 16, 32 or 64. With opcode bit 3 at 0 (little-endian) the low bytes are kept and zero-extended. With bit 3 at 1 (big-endian) the bytes within the width are reversed and zero-extended.
- R9: The unit raises `illegal` together with `done` and leaves every register unchanged in any of these cases: a class other than 4 or 7, an operation 0xe or 0xf, a byte conversion in class 7, a byte conversion width other than 16, 32 or 64, a nonzero offset, or a destination index above 10. The same applies to a source index above 10 when the register operand is used by an operation other than negation or byte conversion.
- R10: Register 10 always reads as the parameter `FRAME_BASE`, including when used as a source. Any instruction naming it as destination is flagged illegal and has no effect.
- R11: After reset, registers 0 to 9 read zero, `done` and `illegal` are low and `op_ready` is high. `dbg_value` returns the register chosen by `dbg_sel` in the same cycle, and returns zero for indices above 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Instruction offered |
| op_ready | output | 1 | Unit can take an instruction |
| op_word | input | 64 | Instruction word |
| dbg_sel | input | 4 | Register index for debug read |
| dbg_value | output | 64 | Contents of the selected register |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completed instruction was rejected (valid with done) |

## Verification
The hardest states to reach are wide operands with chosen upper halves. The only way to load a register is through the unit's own instructions, and immediates are just 32 bits and sign-extended. The bench therefore builds every 64-bit operand from a four-instruction sequence: a zero-extending 32-bit move into a scratch register, a 64-bit move of the upper half, a left shift by 32 and a register OR. Only then does it issue the instruction under test. Masked shift counts, zero-divisor remainders whose divisor is zero only in its low half, and byte conversions of a distinct-byte pattern are all driven this way.

// File: rtl/ixu_pkg.sv
package ixu_pkg;

    localparam int INSN_W = 64;

    // class field values
    localparam logic [2:0] CLS_NARROW = 3'h4;
    localparam logic [2:0] CLS_WIDE   = 3'h7;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'ha,
        OP_MOV  = 4'hb,
        OP_ARSH = 4'hc,
        OP_SWAP = 4'hd
    } alu_op_e;

    typedef struct packed {
        logic [3:0]  op;
        logic        wide;
        logic        use_reg;
        logic [3:0]  dst;
        logic [3:0]  src;
        logic [31:0] imm;
        logic        bad;
    } dec_t;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              bad;
        logic [INSN_W-1:0] insn;
    } ctl_t;

endpackage

// File: rtl/ixu_decode.sv
module ixu_decode
    import ixu_pkg::*;
#(
    parameter int NREGS = 11
) (
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);

    logic [2:0] cls;
    logic       cls_ok;
    logic       op_known;
    logic       is_swap;
    logic       width_ok;
    logic       dst_bad;
    logic       src_bad;
    logic       off_bad;

    always_comb begin
        cls         = insn[2:0];
        dec.op      = insn[7:4];
        dec.use_reg = insn[3];
        dec.dst     = insn[11:8];
        dec.src     = insn[15:12];
        dec.imm     = insn[63:32];
        dec.wide    = (cls == CLS_WIDE);

        cls_ok   = (cls == CLS_NARROW) || (cls == CLS_WIDE);
        op_known = (dec.op <= 4'hd);
        is_swap  = (dec.op == OP_SWAP);
        width_ok = (dec.imm == 32'd16) || (dec.imm == 32'd32) || (dec.imm == 32'd64);
        // the top index is the read-only frame register, so it is excluded too
        dst_bad  = (dec.dst >= 4'(NREGS - 1));
        src_bad  = dec.use_reg && !is_swap && (dec.op != OP_NEG) && (dec.src >= 4'(NREGS));
        off_bad  = (insn[31:16] != 16'h0);

        dec.bad = !cls_ok || !op_known || (is_swap && (dec.wide || !width_ok))
                  || dst_bad || src_bad || off_bad;
    end

endmodule

// File: rtl/ixu_alu.sv
module ixu_alu
    import ixu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0]      op,
    input  logic            wide,
    input  logic            use_reg,
    input  logic [31:0]     imm,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            keep
);

    localparam int NBYTES = XLEN / 8;
    localparam int HALF   = XLEN / 2;
    localparam int SHW    = $clog2(XLEN);

    logic [XLEN-1:0]        rev;
    logic [XLEN-1:0]        opnd;
    logic [XLEN-1:0]        a_t;
    logic [XLEN-1:0]        o_t;
    logic [SHW-1:0]         shamt;
    logic signed [HALF-1:0] sar_lo;
    logic [XLEN-1:0]        raw;
    logic [XLEN-1:0]        le_mask;
    logic [XLEN-1:0]        be_val;

    // full byte reversal; narrower big-endian forms shift it down
    for (genvar g = 0; g < NBYTES; g++) begin : g_rev
        assign rev[g*8 +: 8] = a[(NBYTES-1-g)*8 +: 8];
    end

    always_comb begin
        opnd   = use_reg ? b : {{(XLEN-32){imm[31]}}, imm};
        a_t    = wide ? a    : {{HALF{1'b0}}, a[HALF-1:0]};
        o_t    = wide ? opnd : {{HALF{1'b0}}, opnd[HALF-1:0]};
        shamt  = wide ? o_t[SHW-1:0] : {1'b0, o_t[SHW-2:0]};
        sar_lo = $signed(a_t[HALF-1:0]) >>> shamt[SHW-2:0];

        unique case (imm[6:0])
            7'd16: begin
                le_mask = {{(XLEN-16){1'b0}}, {16{1'b1}}};
                be_val  = rev >> (XLEN - 16);
            end
            7'd32: begin
                le_mask = {{(XLEN-32){1'b0}}, {32{1'b1}}};
                be_val  = rev >> (XLEN - 32);
            end
            default: begin
                le_mask = {XLEN{1'b1}};
                be_val  = rev;
            end
        endcase

        keep = 1'b1;
        unique case (op)
            OP_ADD:  raw = a_t + o_t;
            OP_SUB:  raw = a_t - o_t;
            OP_MUL:  raw = a_t * o_t;
            OP_DIV:  raw = (o_t == '0) ? '0 : a_t / o_t;
            OP_OR:   raw = a_t | o_t;
            OP_AND:  raw = a_t & o_t;
            OP_LSH:  raw = a_t << shamt;
            OP_RSH:  raw = a_t >> shamt;
            OP_NEG:  raw = '0 - a_t;
            OP_MOD: begin
                raw  = (o_t == '0) ? a_t : a_t % o_t;
                keep = (o_t != '0);
            end
            OP_XOR:  raw = a_t ^ o_t;
            OP_MOV:  raw = o_t;
            OP_ARSH: raw = wide ? XLEN'($signed(a_t) >>> shamt) : {{HALF{1'b0}}, sar_lo};
            OP_SWAP: raw = use_reg ? be_val : (a & le_mask);
            default: raw = a_t;
        endcase

        res = (wide || op == OP_SWAP) ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
    end

endmodule

// File: rtl/ixu_regfile.sv
module ixu_regfile #(
    parameter int              XLEN       = 64,
    parameter int              NREGS      = 11,
    parameter logic [XLEN-1:0] FRAME_BASE = 64'h0000_0000_0000_7ff0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      ra_addr,
    output logic [XLEN-1:0] ra_data,
    input  logic [3:0]      rb_addr,
    output logic [XLEN-1:0] rb_data,
    input  logic [3:0]      dbg_addr,
    output logic [XLEN-1:0] dbg_data,
    input  logic            we,
    input  logic [3:0]      waddr,
    input  logic [XLEN-1:0] wdata
);

    localparam int NWR = NREGS - 1;

    logic [XLEN-1:0] regs_q [NWR];
    logic [XLEN-1:0] regs_d [NWR];

    function automatic logic [XLEN-1:0] read_port(input logic [3:0] ad);
        logic [XLEN-1:0] v;
        v = (ad == 4'(NWR)) ? FRAME_BASE : '0;
        for (int i = 0; i < NWR; i++) begin
            if (ad == 4'(i)) v = regs_q[i];
        end
        return v;
    endfunction

    always_comb begin
        for (int i = 0; i < NWR; i++) begin
            regs_d[i] = (we && waddr == 4'(i)) ? wdata : regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWR; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NWR; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign ra_data  = read_port(ra_addr);
    assign rb_data  = read_port(rb_addr);
    assign dbg_data = read_port(dbg_addr);

    // R10
    frame_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr < 4'(NWR)));

endmodule

// File: rtl/ixu_top.sv
module ixu_top
    import ixu_pkg::*;
#(
    parameter int              XLEN       = 64,
    parameter int              NREGS      = 11,
    parameter logic [XLEN-1:0] FRAME_BASE = 64'h0000_0000_0000_7ff0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [INSN_W-1:0] op_word,
    input  logic [3:0]        dbg_sel,
    output logic [XLEN-1:0]   dbg_value,
    output logic              done,
    output logic              illegal
);

    ctl_t            ctl_d, ctl_q;
    dec_t            dec;
    logic [XLEN-1:0] dst_val, src_val, alu_res;
    logic            alu_keep;
    logic            rf_we;
    logic            accept;

    ixu_decode #(.NREGS(NREGS)) decode_i (
        .insn (ctl_q.insn),
        .dec  (dec)
    );

    ixu_regfile #(.XLEN(XLEN), .NREGS(NREGS), .FRAME_BASE(FRAME_BASE)) rf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_addr  (dec.dst),
        .ra_data  (dst_val),
        .rb_addr  (dec.src),
        .rb_data  (src_val),
        .dbg_addr (dbg_sel),
        .dbg_data (dbg_value),
        .we       (rf_we),
        .waddr    (dec.dst),
        .wdata    (alu_res)
    );

    ixu_alu #(.XLEN(XLEN)) alu_i (
        .op      (dec.op),
        .wide    (dec.wide),
        .use_reg (dec.use_reg),
        .imm     (dec.imm),
        .a       (dst_val),
        .b       (src_val),
        .res     (alu_res),
        .keep    (alu_keep)
    );

    assign op_ready = !ctl_q.busy;
    assign accept   = op_valid && op_ready;
    assign rf_we    = ctl_q.busy && !dec.bad && alu_keep;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.bad  = 1'b0;
        if (ctl_q.busy) begin
            ctl_d.busy = 1'b0;
            ctl_d.done = 1'b1;
            ctl_d.bad  = dec.bad;
        end else if (accept) begin
            ctl_d.busy = 1'b1;
            ctl_d.insn = op_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign done    = ctl_q.done;
    assign illegal = ctl_q.bad;

    // R2
    accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !op_ready);

    // R2
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 done);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    illegal_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

    // R9
    reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && dec.bad) |=> illegal);

endmodule

// File: tb/ixu_top_tb.sv
`timescale 1ns/1ps
module ixu_top_tb_top;

    localparam int          CLK_NS = 8;
    localparam logic [63:0] FRAME  = 64'h0000_0000_0000_7ff0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [63:0] op_word = '0;
    logic [3:0]  dbg_sel = '0;
    logic [63:0] dbg_value;
    logic        done;
    logic        illegal;

    int errs = 0;
    int checks = 0;

    ixu_top #(.FRAME_BASE(FRAME)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_ready  (op_ready),
        .op_word   (op_word),
        .dbg_sel   (dbg_sel),
        .dbg_value (dbg_value),
        .done      (done),
        .illegal   (illegal)
    );

    always #(CLK_NS/2) clk = ~clk;

    typedef struct packed {
        logic [7:0]  op;
        logic [31:0] imm;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        ill;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 35;
    // dst = reg 1 (preloaded with a), src = reg 2 (preloaded with b)
    localparam vec_t VECS [NV] = '{
        '{8'h0f, 32'h0, 64'h0000_0001_ffff_ffff, 64'h1, 64'h0000_0002_0000_0000, 1'b0, 8'd4},        // R4 add
        '{8'h0c, 32'h0, 64'h0000_0001_ffff_ffff, 64'h1, 64'h0, 1'b0, 8'd5},                          // R5 add narrow
        '{8'h17, 32'h5, 64'h3, 64'h0, 64'hffff_ffff_ffff_fffe, 1'b0, 8'd3},                          // R3 sub imm
        '{8'h1c, 32'h0, 64'h3, 64'h5, 64'h0000_0000_ffff_fffe, 1'b0, 8'd5},                          // R5 sub narrow
        '{8'h2f, 32'h0, 64'h0000_0001_0000_0001, 64'h10, 64'h0000_0010_0000_0010, 1'b0, 8'd4},       // R4 mul
        '{8'h3f, 32'h0, 64'h64, 64'h7, 64'he, 1'b0, 8'd7},                                           // R7 div
        '{8'h3f, 32'h0, 64'h64, 64'h0, 64'h0, 1'b0, 8'd7},                                           // R7 div by zero
        '{8'h9f, 32'h0, 64'h64, 64'h7, 64'h2, 1'b0, 8'd7},                                           // R7 mod
        '{8'h9f, 32'h0, 64'h64, 64'h0, 64'h64, 1'b0, 8'd7},                                          // R7 mod by zero
        '{8'h9c, 32'h0, 64'hffff_ffff_0000_0005, 64'hffff_ffff_0000_0000, 64'hffff_ffff_0000_0005, 1'b0, 8'd7}, // R7 narrow zero
        '{8'h47, 32'h8000_0000, 64'h0, 64'h0, 64'hffff_ffff_8000_0000, 1'b0, 8'd3},                  // R3 sign extend
        '{8'h44, 32'h8000_0000, 64'h0, 64'h0, 64'h0000_0000_8000_0000, 1'b0, 8'd5},                  // R5 or narrow
        '{8'h5f, 32'h0, 64'hf0f0, 64'hff00, 64'hf000, 1'b0, 8'd4},                                   // R4 and
        '{8'h6f, 32'h0, 64'h1, 64'd65, 64'h2, 1'b0, 8'd6},                                           // R6 mask 6 bits
        '{8'h6c, 32'h0, 64'h1, 64'd36, 64'h10, 1'b0, 8'd6},                                          // R6 mask 5 bits
        '{8'h77, 32'h4, 64'h8000_0000_0000_0000, 64'h0, 64'h0800_0000_0000_0000, 1'b0, 8'd6},        // R6 rsh
        '{8'hc7, 32'h4, 64'h8000_0000_0000_0000, 64'h0, 64'hf800_0000_0000_0000, 1'b0, 8'd6},        // R6 arsh wide
        '{8'hc4, 32'h4, 64'h0000_0000_8000_0000, 64'h0, 64'h0000_0000_f800_0000, 1'b0, 8'd6},        // R6 arsh narrow
        '{8'h87, 32'h0, 64'h1, 64'h0, 64'hffff_ffff_ffff_ffff, 1'b0, 8'd4},                          // R4 neg
        '{8'h84, 32'h0, 64'h1, 64'h0, 64'h0000_0000_ffff_ffff, 1'b0, 8'd5},                          // R5 neg narrow
        '{8'haf, 32'h0, 64'hff00_ff00, 64'h0ff0_0ff0, 64'hf0f0_f0f0, 1'b0, 8'd4},                    // R4 xor
        '{8'hbf, 32'h0, 64'h0, 64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, 1'b0, 8'd4},        // R4 mov
        '{8'hbc, 32'h0, 64'h0, 64'h1234_5678_9abc_def0, 64'h0000_0000_9abc_def0, 1'b0, 8'd5},        // R5 mov narrow
        '{8'hdc, 32'd16, 64'h1122_3344_5566_7788, 64'h0, 64'h8877, 1'b0, 8'd8},                      // R8 be16
        '{8'hdc, 32'd32, 64'h1122_3344_5566_7788, 64'h0, 64'h8877_6655, 1'b0, 8'd8},                 // R8 be32
        '{8'hdc, 32'd64, 64'h1122_3344_5566_7788, 64'h0, 64'h8877_6655_4433_2211, 1'b0, 8'd8},       // R8 be64
        '{8'hd4, 32'd16, 64'h1122_3344_5566_7788, 64'h0, 64'h7788, 1'b0, 8'd8},                      // R8 le16
        '{8'hd4, 32'd32, 64'h1122_3344_5566_7788, 64'h0, 64'h5566_7788, 1'b0, 8'd8},                 // R8 le32
        '{8'hd4, 32'd64, 64'h1122_3344_5566_7788, 64'h0, 64'h1122_3344_5566_7788, 1'b0, 8'd8},       // R8 le64
        '{8'hdc, 32'd8, 64'h1122_3344_5566_7788, 64'h0, 64'h1122_3344_5566_7788, 1'b1, 8'd9},        // R9 bad width
        '{8'he4, 32'h0, 64'h1122_3344_5566_7788, 64'h0, 64'h1122_3344_5566_7788, 1'b1, 8'd9},        // R9 unknown op
        '{8'h08, 32'h0, 64'h1122_3344_5566_7788, 64'h0, 64'h1122_3344_5566_7788, 1'b1, 8'd9},        // R9 bad class
        '{8'hd7, 32'd16, 64'h1122_3344_5566_7788, 64'h0, 64'h1122_3344_5566_7788, 1'b1, 8'd9},       // R9 swap wide class
        '{8'hc4, 32'h24, 64'h0000_0000_8000_0000, 64'h0, 64'h0000_0000_f800_0000, 1'b0, 8'd6},       // R6 masked imm
        '{8'h6c, 32'h0, 64'h8000_0000, 64'h1, 64'h0, 1'b0, 8'd6}                                     // R6 narrow overflow
    };

    function automatic logic [63:0] enc(input logic [7:0] op, input logic [3:0] d,
                                        input logic [3:0] s, input logic [15:0] off,
                                        input logic [31:0] imm);
        return {imm, off, s, d, op};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [63:0] w, output logic d, output logic il);
        @(negedge clk);
        op_valid = 1'b1;
        op_word  = w;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        d  = done;
        il = illegal;
    endtask

    task automatic peek(input logic [3:0] idx, output logic [63:0] v);
        dbg_sel = idx;
        #1;
        v = dbg_value;
    endtask

    task automatic load(input logic [3:0] idx, input logic [63:0] val);
        logic d, il;
        issue(enc(8'hb4, 4'd9, 4'd0, 16'h0, val[31:0]), d, il);
        issue(enc(8'hb7, idx, 4'd0, 16'h0, val[63:32]), d, il);
        issue(enc(8'h67, idx, 4'd0, 16'h0, 32'd32), d, il);
        issue(enc(8'h4f, idx, 4'd9, 16'h0, 32'h0), d, il);
    endtask

    initial begin
        #(CLK_NS * 200000);
        errs++;
        checks++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic        d, il;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        for (int i = 0; i < 10; i++) begin
            peek(4'(i), v);
            chk($sformatf("R11 reset reg %0d", i), v, 64'h0);
        end
        chk("R11 ready after reset", {63'h0, op_ready}, 64'h1);
        chk("R11 done after reset", {63'h0, done}, 64'h0);
        chk("R11 illegal after reset", {63'h0, illegal}, 64'h0);
        peek(4'd12, v);
        chk("R11 out of range debug read", v, 64'h0);
        peek(4'd10, v);
        chk("R10 frame register value", v, FRAME);

        // R2 handshake, valid held through the busy cycle
        @(negedge clk);
        op_valid = 1'b1;
        op_word  = enc(8'h07, 4'd4, 4'd0, 16'h0, 32'h1);
        @(negedge clk);
        chk("R2 ready low while busy", {63'h0, op_ready}, 64'h0);
        chk("R2 done low while busy", {63'h0, done}, 64'h0);
        @(negedge clk);
        chk("R2 done pulse", {63'h0, done}, 64'h1);
        chk("R2 ready back", {63'h0, op_ready}, 64'h1);
        op_valid = 1'b0;
        @(negedge clk);
        chk("R2 done single cycle", {63'h0, done}, 64'h0);
        peek(4'd4, v);
        chk("R2 single acceptance", v, 64'h1);

        // R1 field layout with distinct indices
        load(4'd5, 64'd10);
        load(4'd6, 64'd20);
        issue(enc(8'h0f, 4'd5, 4'd6, 16'h0, 32'h0), d, il);
        peek(4'd5, v);
        chk("R1 destination field", v, 64'd30);
        peek(4'd6, v);
        chk("R1 source untouched", v, 64'd20);

        // R1 nonzero offset rejected
        issue(enc(8'h07, 4'd5, 4'd0, 16'h0001, 32'h1), d, il);
        chk("R1 offset flagged", {63'h0, il}, 64'h1);
        peek(4'd5, v);
        chk("R1 offset no effect", v, 64'd30);

        // R10 write to frame register
        issue(enc(8'hb7, 4'd10, 4'd0, 16'h0, 32'h5), d, il);
        chk("R10 write flagged", {63'h0, il}, 64'h1);
        chk("R10 write done", {63'h0, d}, 64'h1);
        peek(4'd10, v);
        chk("R10 unchanged", v, FRAME);
        issue(enc(8'hbf, 4'd3, 4'd10, 16'h0, 32'h0), d, il);
        peek(4'd3, v);
        chk("R10 readable as source", v, FRAME);
        chk("R10 source not flagged", {63'h0, il}, 64'h0);

        // R9 bad register indices
        issue(enc(8'hb7, 4'd11, 4'd0, 16'h0, 32'h5), d, il);
        chk("R9 destination index 11", {63'h0, il}, 64'h1);
        issue(enc(8'hbf, 4'd5, 4'd12, 16'h0, 32'h0), d, il);
        chk("R9 source index 12", {63'h0, il}, 64'h1);
        peek(4'd5, v);
        chk("R9 bad source no effect", v, 64'd30);

        // table: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            load(4'd1, VECS[i].a);
            load(4'd2, VECS[i].b);
            issue(enc(VECS[i].op, 4'd1, 4'd2, 16'h0, VECS[i].imm), d, il);
            chk($sformatf("R%0d vector %0d done", VECS[i].rq, i), {63'h0, d}, 64'h1);
            chk($sformatf("R%0d vector %0d illegal", VECS[i].rq, i), {63'h0, il}, {63'h0, VECS[i].ill});
            peek(4'd1, v);
            chk($sformatf("R%0d vector %0d result", VECS[i].rq, i), v, VECS[i].exp);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule